// File: doc/BRIEF.md
# Per-Pair Power-Down Sequencer

This block sequences conversion starts and power states for a group of converter pairs that share one conversion timer. Each pair has its own start input, and a rising edge on it requests a conversion. When a conversion finishes, every pair that took part in it and whose start input is low at that moment drops into partial power-down. A powered-down pair wakes when its start input rises again. After a programmable wake interval it accepts conversion starts once more. Start edges that arrive while a pair is waking are refused and flagged.

A global active-low standby input puts the whole device into its low-power state. Standby switches off the reference buffers and every pair. When standby is released, a second wake interval runs before any start is honoured. Conversion results are captured into per-pair result registers when a conversion ends. They stay readable through a select port at all times, including during standby. The analog conversion itself is modelled only as a fixed number of clock cycles.

Top module: `psq_sequencer`

## Requirements
- R1: A rising edge on a pair's start input is accepted when the device is out of standby and standby wake, the pair is fully powered and not waking, and BUSY is low. BUSY reads high in the next cycle. While BUSY is high, a converting pair shows track low (hold) and power high.
- R2: BUSY stays high for exactly CONV_CYCLES cycles after it rises, then falls.
- R3: A pair that took part in the conversion and whose start input is low in the last cycle with BUSY high shows power low and track low from the cycle in which BUSY first reads low.
- R4: A pair that did not take part in the finished conversion stays powered, even when its start input is low when BUSY falls.
- R5: A rising start edge on a powered-down pair begins its wake-up. In the next cycle its power and track read high, with no conversion and no invalid pulse. After WAKE_CYCLES cycles a new rising edge is accepted as a conversion start.
- R6: A rising start edge on a pair that is still waking starts nothing. It drives the invalid flag high for one cycle, in the cycle after the edge.
- R7: A fully powered pair can start and complete a conversion while another pair is in partial power-down.
- R8: The reference-buffer flag stays high through partial power-down and conversions. It is low only while the device is in standby.
- R9: In the cycle after the standby input goes low, the reference flag and every pair's power and track read low. After release, the reference flag reads high in the next cycle, and starts are refused for STBY_WAKE_CYCLES cycles.
- R10: A rising start edge during standby or during the standby wake interval starts no conversion. It pulses the invalid flag in the cycle after the edge.
- R11: At the end of a conversion, each converting pair's result register loads its DATA_W-bit slice of the sample input (pair p at bits p*DATA_W upward). Pairs that did not convert keep their old value. The register addressed by the read select appears on the read data output combinationally, also during standby.
- R12: A rising start edge on a powered pair while BUSY is high is ignored: it starts nothing and raises no invalid pulse.
- R13: After reset, BUSY is low, every pair's power and track are high, the reference flag is high, the invalid flag is low and all results read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | N_PAIRS | Per-pair conversion-start levels |
| stby_n_i | input | 1 | Active-low global standby request |
| sample_i | input | N_PAIRS*DATA_W | Per-pair sample values captured at conversion end |
| rd_sel_i | input | SEL_W | Result register select |
| busy_o | output | 1 | Conversion in progress |
| pwr_o | output | N_PAIRS | Per-pair fully-powered status |
| track_o | output | N_PAIRS | Per-pair track (1) / hold (0) status |
| ref_on_o | output | 1 | Reference buffers powered |
| invalid_o | output | 1 | One-cycle pulse for a refused start edge |
| rd_data_o | output | DATA_W | Selected result register |

## Verification
Every registered result is due one clock after the edge that causes it. This covers BUSY rising after an accepted edge, the invalid pulse after a refused edge, power and track changes at wake or standby, and power-down in the same cycle that BUSY first reads low. Only the read data follows the select in the same cycle. The bench drives inputs just after the falling clock edge. A behavioural model steps on the rising edge from the same inputs, and all outputs are compared at the next falling edge, so each result is sampled in the cycle it is due. Directed checks wait for BUSY to read low, or count whole cycles after a drive, before they compare against expected values.

// File: rtl/psq_pkg.sv
package psq_pkg;

   typedef enum logic [1:0] {
      PAIR_ON   = 2'd0,
      PAIR_OFF  = 2'd1,
      PAIR_WAKE = 2'd2
   } pair_st_t;

   typedef enum logic [1:0] {
      DEV_RUN  = 2'd0,
      DEV_STBY = 2'd1,
      DEV_WAKE = 2'd2
   } dev_st_t;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/psq_edge_detect.sv
module psq_edge_detect #(
   parameter int N_BITS      = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] raw_i,
   output logic [N_BITS-1:0] lvl_o,
   output logic [N_BITS-1:0] rise_o
);

   logic [N_BITS-1:0] lvl_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl_o = raw_i;
      end else begin : g_sync
         logic [N_BITS-1:0] chain_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) chain_q[s] <= '0;
            end else begin
               chain_q[0] <= raw_i;
               for (int s = 1; s < SYNC_STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign lvl_o = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_o;
   end

   assign rise_o = lvl_o & ~lvl_q;

endmodule

// File: rtl/psq_conv_timer.sv
module psq_conv_timer #(
   parameter int CONV_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   output logic busy_o,
   output logic done_o
);

   localparam int CW = psq_pkg::cnt_width(CONV_CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   assign done_o = busy_q && (cnt_q == '0);
   assign busy_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (done_o) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (launch_i) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end
   end

endmodule

// File: rtl/psq_standby_ctrl.sv
module psq_standby_ctrl #(
   parameter int STBY_WAKE_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stby_n_i,
   output logic ready_o,
   output logic asleep_o
);

   import psq_pkg::*;

   localparam int GW = cnt_width(STBY_WAKE_CYCLES);
   localparam logic [GW-1:0] LOAD = GW'(STBY_WAKE_CYCLES - 1);

   dev_st_t       st_q;
   logic [GW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= DEV_RUN;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            DEV_RUN:  if (!stby_n_i) st_q <= DEV_STBY;
            DEV_STBY: if (stby_n_i) begin
                         st_q  <= DEV_WAKE;
                         cnt_q <= LOAD;
                      end
            DEV_WAKE: if (!stby_n_i)          st_q  <= DEV_STBY;
                      else if (cnt_q == '0)   st_q  <= DEV_RUN;
                      else                    cnt_q <= cnt_q - 1'b1;
            default:  st_q <= DEV_RUN;
         endcase
      end
   end

   assign ready_o  = (st_q == DEV_RUN);
   assign asleep_o = (st_q == DEV_STBY);

endmodule

// File: rtl/psq_pair_ctrl.sv
module psq_pair_ctrl #(
   parameter int WAKE_CYCLES = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   input  logic lvl_i,
   input  logic dev_ready_i,
   input  logic busy_i,
   input  logic done_i,
   output logic accept_o,
   output logic reject_o,
   output logic powered_o,
   output logic conv_o
);

   import psq_pkg::*;

   localparam int WW = cnt_width(WAKE_CYCLES);
   localparam logic [WW-1:0] LOAD = WW'(WAKE_CYCLES - 1);

   pair_st_t      st_q;
   logic [WW-1:0] cnt_q;
   logic          conv_q;

   assign accept_o  = rise_i && dev_ready_i && (st_q == PAIR_ON) && !busy_i;
   assign reject_o  = rise_i && (!dev_ready_i || (st_q == PAIR_WAKE));
   assign powered_o = (st_q != PAIR_OFF);
   assign conv_o    = conv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q <= 1'b0;
      end else if (done_i) begin
         conv_q <= 1'b0;
      end else if (accept_o) begin
         conv_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PAIR_ON;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            PAIR_ON:   if (done_i && conv_q && !lvl_i) st_q <= PAIR_OFF;
            PAIR_OFF:  if (rise_i && dev_ready_i) begin
                          st_q  <= PAIR_WAKE;
                          cnt_q <= LOAD;
                       end
            PAIR_WAKE: if (cnt_q == '0) st_q  <= PAIR_ON;
                       else             cnt_q <= cnt_q - 1'b1;
            default:   st_q <= PAIR_ON;
         endcase
      end
   end

endmodule

// File: rtl/psq_sequencer.sv
module psq_sequencer #(
   parameter int N_PAIRS          = 3,
   parameter int DATA_W           = 16,
   parameter int CONV_CYCLES      = 40,
   parameter int WAKE_CYCLES      = 24,
   parameter int STBY_WAKE_CYCLES = 64,
   parameter int SYNC_STAGES      = 0,
   localparam int SEL_W           = psq_pkg::cnt_width(N_PAIRS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_PAIRS-1:0]        start_i,
   input  logic                      stby_n_i,
   input  logic [N_PAIRS*DATA_W-1:0] sample_i,
   input  logic [SEL_W-1:0]          rd_sel_i,
   output logic                      busy_o,
   output logic [N_PAIRS-1:0]        pwr_o,
   output logic [N_PAIRS-1:0]        track_o,
   output logic                      ref_on_o,
   output logic                      invalid_o,
   output logic [DATA_W-1:0]         rd_data_o
);

   generate
      if (N_PAIRS < 1)          begin : g_bad_pairs $error("N_PAIRS must be at least 1"); end
      if (DATA_W < 1)           begin : g_bad_width $error("DATA_W must be at least 1"); end
      if (CONV_CYCLES < 1)      begin : g_bad_conv  $error("CONV_CYCLES must be at least 1"); end
      if (WAKE_CYCLES < 1)      begin : g_bad_wake  $error("WAKE_CYCLES must be at least 1"); end
      if (STBY_WAKE_CYCLES < 1) begin : g_bad_stby  $error("STBY_WAKE_CYCLES must be at least 1"); end
      if (SYNC_STAGES < 0)      begin : g_bad_sync  $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic [N_PAIRS-1:0] lvl, rise, accept, reject, powered, conv;
   logic               busy, done, dev_ready, asleep;
   logic               invalid_q;
   logic [DATA_W-1:0]  res_q [N_PAIRS];

   psq_edge_detect #(.N_BITS(N_PAIRS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .raw_i(start_i), .lvl_o(lvl), .rise_o(rise)
   );

   psq_standby_ctrl #(.STBY_WAKE_CYCLES(STBY_WAKE_CYCLES)) u_stby (
      .clk(clk), .rst_n(rst_n), .stby_n_i(stby_n_i),
      .ready_o(dev_ready), .asleep_o(asleep)
   );

   psq_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .launch_i(|accept),
      .busy_o(busy), .done_o(done)
   );

   generate
      for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
         psq_pair_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_pair (
            .clk(clk), .rst_n(rst_n),
            .rise_i(rise[p]), .lvl_i(lvl[p]),
            .dev_ready_i(dev_ready), .busy_i(busy), .done_i(done),
            .accept_o(accept[p]), .reject_o(reject[p]),
            .powered_o(powered[p]), .conv_o(conv[p])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              res_q[p] <= '0;
            else if (done && conv[p]) res_q[p] <= sample_i[p*DATA_W +: DATA_W];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) invalid_q <= 1'b0;
      else        invalid_q <= |reject;
   end

   always_comb begin
      rd_data_o = '0;
      for (int p = 0; p < N_PAIRS; p++) begin
         if (int'(rd_sel_i) == p) rd_data_o = res_q[p];
      end
   end

   assign busy_o    = busy;
   assign pwr_o     = powered & {N_PAIRS{!asleep}};
   assign track_o   = pwr_o & ~(conv & {N_PAIRS{busy}});
   assign ref_on_o  = !asleep;
   assign invalid_o = invalid_q;

endmodule

// File: rtl/psq_checker.sv
module psq_checker #(
   parameter int N_PAIRS     = 3,
   parameter int CONV_CYCLES = 40
) (
   input logic               clk,
   input logic               rst_n,
   input logic               stby_n_i,
   input logic               busy_o,
   input logic [N_PAIRS-1:0] pwr_o,
   input logic [N_PAIRS-1:0] track_o,
   input logic               ref_on_o
);

   localparam int RW = $clog2(CONV_CYCLES + 1) + 1;

   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (busy_o) run_q <= run_q + 1'b1;
      else             run_q <= '0;
   end

   assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (track_o != pwr_o));

   assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_q == RW'(CONV_CYCLES)));

   assert_busy_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (run_q < RW'(CONV_CYCLES)));

   assert_ref_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_on_o) |-> !$past(stby_n_i));

   assert_stby_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_on_o |-> ((pwr_o == '0) && (track_o == '0)));

   assert_stby_nostart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_on_o && !busy_o) |=> !busy_o);

   generate
      for (genvar p = 0; p < N_PAIRS; p++) begin : g_pd
         assert_pd_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pwr_o[p]) && ref_on_o) |-> $fell(busy_o));
      end
   endgenerate

endmodule

bind psq_sequencer psq_checker #(.N_PAIRS(N_PAIRS), .CONV_CYCLES(CONV_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .stby_n_i(stby_n_i), .busy_o(busy_o),
   .pwr_o(pwr_o), .track_o(track_o), .ref_on_o(ref_on_o)
);

// File: tb/tb_psq_sequencer.sv
`timescale 1ns/1ps
module tb_psq_sequencer;

   localparam int NP = 3;
   localparam int DW = 16;
   localparam int C  = 6;
   localparam int W  = 4;
   localparam int SW = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     start_r = '0;
   logic              stby_n_r = 1'b1;
   logic [NP*DW-1:0]  sample_r = {16'h3333, 16'h2222, 16'h1111};
   logic [1:0]        rd_sel_r = '0;
   logic              busy_o, ref_on_o, invalid_o;
   logic [NP-1:0]     pwr_o, track_o;
   logic [DW-1:0]     rd_data_o;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;
   bit done_run = 1'b0;

   always #2.5 clk = ~clk;

   psq_sequencer #(.N_PAIRS(NP), .DATA_W(DW), .CONV_CYCLES(C),
                   .WAKE_CYCLES(W), .STBY_WAKE_CYCLES(SW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_r), .stby_n_i(stby_n_r),
      .sample_i(sample_r), .rd_sel_i(rd_sel_r), .busy_o(busy_o), .pwr_o(pwr_o),
      .track_o(track_o), .ref_on_o(ref_on_o), .invalid_o(invalid_o), .rd_data_o(rd_data_o)
   );

   // behavioural model state: pair state 0 on, 1 off, 2 waking; device 0 run, 1 standby, 2 waking
   int m_busy, m_cnt, m_gst, m_gcnt, m_inv;
   int m_pst [NP];
   int m_pcnt [NP];
   int m_conv [NP];
   int m_prev [NP];
   int m_res [NP];
   int acc [NP];
   int old_st, any_acc, end_evt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; m_gst = 0; m_gcnt = 0; m_inv = 0;
         for (int p = 0; p < NP; p++) begin
            m_pst[p] = 0; m_pcnt[p] = 0; m_conv[p] = 0; m_prev[p] = 0; m_res[p] = 0;
         end
      end else begin
         end_evt = (m_busy == 1 && m_cnt == 0);
         m_inv = 0;
         any_acc = 0;
         for (int p = 0; p < NP; p++) begin
            old_st = m_pst[p];
            acc[p] = 0;
            if (old_st == 2) begin
               if (m_pcnt[p] == 0) m_pst[p] = 0;
               else m_pcnt[p] = m_pcnt[p] - 1;
            end
            if (start_r[p] && m_prev[p] == 0) begin
               if (m_gst != 0) m_inv = 1;
               else if (old_st == 1) begin m_pst[p] = 2; m_pcnt[p] = W - 1; end
               else if (old_st == 2) m_inv = 1;
               else if (m_busy == 0) begin acc[p] = 1; any_acc = 1; end
            end
            if (end_evt && m_conv[p] == 1) begin
               if (!start_r[p]) m_pst[p] = 1;
               m_res[p] = int'(sample_r[p*DW +: DW]);
               m_conv[p] = 0;
            end
            m_prev[p] = int'(start_r[p]);
         end
         if (end_evt) m_busy = 0;
         else if (m_busy == 1) m_cnt = m_cnt - 1;
         else if (any_acc == 1) begin
            m_busy = 1; m_cnt = C - 1;
            for (int p = 0; p < NP; p++) m_conv[p] = acc[p];
         end
         case (m_gst)
            0: if (!stby_n_r) m_gst = 1;
            1: if (stby_n_r) begin m_gst = 2; m_gcnt = SW - 1; end
            default: if (!stby_n_r) m_gst = 1;
                     else if (m_gcnt == 0) m_gst = 0;
                     else m_gcnt = m_gcnt - 1;
         endcase
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && !done_run) begin
         int e_pwr, e_trk;
         e_pwr = 0; e_trk = 0;
         for (int p = 0; p < NP; p++) begin
            if (m_pst[p] != 1 && m_gst != 1) begin
               e_pwr |= (1 << p);
               if (!(m_busy == 1 && m_conv[p] == 1)) e_trk |= (1 << p);
            end
         end
         chk("R2 model busy", int'(busy_o), m_busy);
         chk("R3 model pwr", int'(pwr_o), e_pwr);
         chk("R1 model track", int'(track_o), e_trk);
         chk("R8 model ref_on", int'(ref_on_o), (m_gst != 1) ? 1 : 0);
         chk("R6 model invalid", int'(invalid_o), m_inv);
         chk("R11 model rd_data", int'(rd_data_o), (int'(rd_sel_r) < NP) ? m_res[rd_sel_r] : 0);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy_o && guard < 100) begin step(1); guard++; end
   endtask

   task automatic finish_run();
      if (!done_run) begin
         done_run = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      // R13 reset state
      chk("R13 busy", int'(busy_o), 0);
      chk("R13 pwr", int'(pwr_o), 7);
      chk("R13 track", int'(track_o), 7);
      chk("R13 ref", int'(ref_on_o), 1);
      chk("R13 invalid", int'(invalid_o), 0);
      chk("R13 result", int'(rd_data_o), 0);
      step(2);
      // R1 start pairs 0 and 1 together
      start_r = 3'b011;
      step(1);
      chk("R1 busy rises", int'(busy_o), 1);
      chk("R1 track hold", int'(track_o), 3'b100);
      start_r = 3'b010;
      wait_idle();
      // R3 pair0 low at end -> down; R4 pair2 idle and low stays up
      chk("R3 pair0 down", int'(pwr_o), 3'b110);
      chk("R4 idle pair up", int'(pwr_o[2]), 1);
      chk("R8 ref in partial", int'(ref_on_o), 1);
      rd_sel_r = 2'd0;
      #0.1;
      chk("R11 pair0 result", int'(rd_data_o), 16'h1111);
      sample_r = {16'h7333, 16'h7222, 16'h7111};
      // R7 pair2 converts while pair0 is down
      start_r = 3'b110;
      step(1);
      chk("R7 busy with pair0 down", int'(busy_o), 1);
      // R12 edge on pair1 during busy ignored
      start_r = 3'b100;
      step(1);
      start_r = 3'b110;
      step(1);
      chk("R12 no invalid", int'(invalid_o), 0);
      wait_idle();
      chk("R7 pair2 stays up", int'(pwr_o), 3'b110);
      step(2);
      chk("R12 no new busy", int'(busy_o), 0);
      // R5 wake pair0
      start_r = 3'b111;
      step(1);
      chk("R5 wake power", int'(pwr_o[0]), 1);
      chk("R5 wake no busy", int'(busy_o), 0);
      chk("R5 wake no invalid", int'(invalid_o), 0);
      start_r = 3'b110;
      step(1);
      start_r = 3'b111;
      step(1);
      chk("R6 invalid in wake", int'(invalid_o), 1);
      chk("R6 no busy in wake", int'(busy_o), 0);
      step(1);
      chk("R6 pulse one cycle", int'(invalid_o), 0);
      step(W + 2);
      start_r = 3'b110;
      step(1);
      start_r = 3'b111;
      step(1);
      chk("R5 accepted after wake", int'(busy_o), 1);
      wait_idle();
      step(1);
      // R9 standby
      stby_n_r = 1'b0;
      step(1);
      chk("R9 ref off", int'(ref_on_o), 0);
      chk("R9 pwr off", int'(pwr_o), 0);
      chk("R9 track off", int'(track_o), 0);
      rd_sel_r = 2'd1;
      #0.1;
      chk("R11 read in standby pair1", int'(rd_data_o), 16'h2222);
      rd_sel_r = 2'd2;
      #0.1;
      chk("R11 read in standby pair2", int'(rd_data_o), 16'h7333);
      start_r = 3'b011;
      step(1);
      start_r = 3'b111;
      step(1);
      chk("R10 invalid in standby", int'(invalid_o), 1);
      chk("R10 no busy in standby", int'(busy_o), 0);
      stby_n_r = 1'b1;
      step(1);
      chk("R9 ref back", int'(ref_on_o), 1);
      start_r = 3'b011;
      step(1);
      start_r = 3'b111;
      step(1);
      chk("R10 invalid in standby wake", int'(invalid_o), 1);
      chk("R10 no busy in standby wake", int'(busy_o), 0);
      step(SW + 2);
      start_r = 3'b011;
      step(1);
      start_r = 3'b111;
      step(1);
      chk("R9 start after standby wake", int'(busy_o), 1);
      wait_idle();
      step(4);
      finish_run();
   end

endmodule